// File: doc/BRIEF.md
# Qualified Sample Record Packer

This block sits between an acquisition front end and a word-wide transfer FIFO. Each cycle it may receive a sample word with a strobe and a keep/discard qualifier from upstream filtering. Every kept sample is paired with the current value of a free-running 64-bit microsecond timestamp and parked in a local record buffer. Discarded samples leave no trace in the output. Because capture only ever writes to this buffer, a slow or stalled output path never causes an incoming sample to be missed while there is room left.

The transfer side waits until a full group of `BURST` records is held. It then emits the group as one uninterrupted run of 32-bit words over a valid/ready handshake. Each record becomes three words: the sample, the lower timestamp half, then the upper timestamp half. A reader that takes every third word therefore recovers each channel, and a reader that consumes whole groups of `3*BURST` words stays aligned to records. A sticky loss flag reports a dropped sample or an output stall that exceeds a cycle limit. A saturating counter totals the dropped samples.

Top module: `sample_record_packer`

## Requirements
- R1: After reset, out_valid, loss_flag and drop_count are all 0, and the timestamp starts at 0.
- R2: A kept sample is tagged with the number of us_tick pulses seen on earlier clock edges (a tick in the same cycle as the strobe counts only for later samples). The count wraps modulo 2^64.
- R3: A strobe with smp_keep low produces no output words and takes no buffer space.
- R4: out_valid rises only when at least BURST records are buffered. Each burst is exactly 3*BURST accepted words.
- R5: Each record goes out as three consecutive words: the sample (word 0), then timestamp bits 31:0 (word 1), then timestamp bits 63:32 (word 2). Records leave in arrival order.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable on the next cycle.
- R7: Once a burst starts, out_valid stays high until its last word is accepted.
- R8: Kept samples that arrive while the buffer holds fewer than BUF_DEPTH records are all stored and later sent, even while out_ready is held low.
- R9: A kept sample that arrives while the buffer is full is discarded. It sets loss_flag and increments drop_count, which saturates at its all-ones value.
- R10: If out_valid is high with out_ready low for STALL_LIMIT consecutive cycles, loss_flag is set.
- R11: loss_flag stays set until loss_clr is pulsed. A new loss event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond; advances the timestamp |
| smp_data | input | 32 | Sample word |
| smp_stb | input | 1 | Sample present this cycle |
| smp_keep | input | 1 | Upstream qualifier: 1 keeps the sample, 0 discards it |
| out_data | output | 32 | Output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Transfer FIFO accepts the word |
| loss_clr | input | 1 | Clears the sticky loss flag |
| loss_flag | output | 1 | Sticky flag for a drop or an output stall past the limit |
| drop_count | output | DROP_W | Saturating count of dropped samples |

## Verification
The assertions check the handshake rules on every cycle:
- valid and data hold under back-pressure;
- a burst is never broken off before its last word;
- a burst starts only with a full group buffered;
- the loss flag is sticky and is raised by every drop;
- the drop counter never decreases.

Only the bench scenarios can show the payload. A reference queue checks the word order, the timestamp values and the absence of discarded samples. Directed sequences show that the buffer fills to exactly its depth with no loss, that drops saturate the counter, and that the stall limit sets the flag after it has been cleared.

// File: rtl/sample_record_packer.sv
module sample_record_packer #(
  parameter int BURST       = 32,
  parameter int BUF_DEPTH   = 64,
  parameter int STALL_LIMIT = 1024,
  parameter int DROP_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic [31:0]       smp_data,
  input  logic              smp_stb,
  input  logic              smp_keep,
  output logic [31:0]       out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              loss_clr,
  output logic              loss_flag,
  output logic [DROP_W-1:0] drop_count
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int CW = $clog2(BUF_DEPTH + 1);
  localparam int BW = $clog2(BURST);
  localparam int SW = $clog2(STALL_LIMIT + 1);

  logic [31:0]   mem_d [BUF_DEPTH];
  logic [63:0]   mem_t [BUF_DEPTH];
  logic [63:0]   ts;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          busy;
  logic [1:0]    word;
  logic [BW-1:0] rec;
  logic [SW-1:0] stall_cnt;

  wire take      = smp_stb & smp_keep;
  wire full      = fill == CW'(BUF_DEPTH);
  wire push      = take & ~full;
  wire drop      = take & full;
  wire fire      = out_valid & out_ready;
  wire pop       = fire & (word == 2'd2);
  wire burst_end = pop & (rec == BW'(BURST - 1));
  wire stalled   = out_valid & ~out_ready;
  wire stall_hit = stalled & (stall_cnt == SW'(STALL_LIMIT - 1));

  assign out_valid = busy;

  always_comb begin
    case (word)
      2'd0:    out_data = mem_d[rd_ptr];
      2'd1:    out_data = mem_t[rd_ptr][31:0];
      default: out_data = mem_t[rd_ptr][63:32];
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wr_ptr] <= smp_data;
      mem_t[wr_ptr] <= ts;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts         <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fill       <= '0;
      busy       <= 1'b0;
      word       <= '0;
      rec        <= '0;
      stall_cnt  <= '0;
      loss_flag  <= 1'b0;
      drop_count <= '0;
    end else begin
      ts   <= ts + 64'(us_tick);
      fill <= fill + CW'(push) - CW'(pop);
      if (push) wr_ptr <= (wr_ptr == AW'(BUF_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(BUF_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;

      if (!busy) begin
        if (fill >= CW'(BURST)) begin
          busy <= 1'b1;
          word <= '0;
          rec  <= '0;
        end
      end else if (fire) begin
        if (word == 2'd2) begin
          word <= '0;
          if (burst_end) busy <= 1'b0;
          else           rec  <= rec + 1'b1;
        end else begin
          word <= word + 1'b1;
        end
      end

      if (!stalled)                           stall_cnt <= '0;
      else if (stall_cnt != SW'(STALL_LIMIT)) stall_cnt <= stall_cnt + 1'b1;

      if (drop | stall_hit) loss_flag <= 1'b1;
      else if (loss_clr)    loss_flag <= 1'b0;

      if (drop && drop_count != '1) drop_count <= drop_count + 1'b1;
    end
  end

  a_r4_full_group: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fill) >= CW'(BURST));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r7_no_break: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !burst_end |=> out_valid);
  a_r9_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> loss_flag && drop_count != '0);
  a_r9_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(drop_count) |=> drop_count >= $past(drop_count));
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    loss_flag && !loss_clr |=> loss_flag);
endmodule

// File: tb/sample_record_packer_tb.sv
module sample_record_packer_tb;
  localparam int BURST = 32, DEPTH = 64, STALL = 200, DW = 3;
  localparam int GROUP = 3 * BURST;

  logic clk = 0, rst_n = 0, us_tick = 0, smp_stb = 0, smp_keep = 0;
  logic out_ready = 0, loss_clr = 0;
  logic [31:0] smp_data = '0;
  logic [31:0] out_data;
  logic out_valid, loss_flag;
  logic [DW-1:0] drop_count;

  sample_record_packer #(.BURST(BURST), .BUF_DEPTH(DEPTH), .STALL_LIMIT(STALL), .DROP_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .smp_data(smp_data), .smp_stb(smp_stb),
    .smp_keep(smp_keep), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .loss_clr(loss_clr), .loss_flag(loss_flag), .drop_count(drop_count));

  always #10 clk = ~clk;

  int total = 0, fails = 0, wcnt = 0;
  logic [63:0] ts_m = '0;
  logic [31:0] expq[$];
  logic prev_stall = 0;
  logic [31:0] prev_data = '0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rec_word(logic [31:0] d, logic [63:0] t, int k);
    return (k == 0) ? d : (k == 1) ? t[31:0] : t[63:32];
  endfunction

  task automatic step(bit s, bit k, bit t, logic [31:0] d, bit rdy, bit dropped = 0);
    @(posedge clk); #2;
    smp_stb = s; smp_keep = k; us_tick = t; smp_data = d; out_ready = rdy;
    if (s && k && !dropped)
      for (int j = 0; j < 3; j++) expq.push_back(rec_word(d, ts_m, j));
    if (t) ts_m++;
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, rdy);
  endtask

  task automatic drain(bit rnd);
    for (int i = 0; i < 20000; i++) begin
      step(0, 0, $urandom % 2, '0, rnd ? ($urandom % 4 != 0) : 1'b1);
      @(negedge clk);
      if (!out_valid && expq.size() < GROUP) break;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (prev_stall) begin
      chk(out_valid === 1'b1, "R6 valid held", out_valid, 1);
      chk(out_data === prev_data, "R6 data stable", out_data, prev_data);
    end
    if (!out_valid && wcnt != 0) chk(0, "R7 burst broken", wcnt, GROUP);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R3 unexpected word", out_data, 0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(out_data === e, "R5/R2 word content", out_data, e);
      end
      wcnt = (wcnt + 1 == GROUP) ? 0 : wcnt + 1;
    end
    prev_stall = out_valid && !out_ready;
    prev_data = out_data;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(out_valid === 0, "R1 valid", out_valid, 0);
    chk(loss_flag === 0, "R1 flag", loss_flag, 0);
    chk(drop_count === 0, "R1 drops", drop_count, 0);

    // R2: first sample carries timestamp 0; R3: discarded strobes interleaved
    for (int i = 0; i < BURST - 1; i++) begin
      step(1, 1, (i > 0) && (i % 3 == 0), 32'hA000 + i, 1);
      step(1, 0, 0, 32'hDEAD, 1);
    end
    idle(10, 1);
    @(negedge clk);
    chk(out_valid === 0, "R4 no burst below group", out_valid, 0);
    step(1, 1, 1, 32'hA0FF, 1);
    idle(3, 1);
    @(negedge clk);
    chk(out_valid === 1, "R4 burst starts at group", out_valid, 1);
    drain(0);
    chk(expq.size() == 0, "R4 exact burst length", expq.size(), 0);

    // random mix: keep qualifier, ticks, back-pressure
    for (int i = 0; i < 2400; i++)
      step(i % 4 == 0, $urandom % 10 < 6, $urandom % 2, $urandom, $urandom % 4 != 0);
    drain(1);
    chk(expq.size() % 3 == 0 && expq.size() < GROUP, "R4 remainder below group", expq.size(), 0);
    chk(loss_flag === 0, "R8 no loss in random mix", loss_flag, 0);
    chk(drop_count === 0, "R8 no drops in random mix", drop_count, 0);

    // stall: fill buffer exactly, then overflow
    begin
      int held;
      held = expq.size() / 3;
      for (int i = 0; i < DEPTH - held; i++) step(1, 1, 1, 32'hB000 + i, 0);
      idle(2, 0);
      @(negedge clk);
      chk(loss_flag === 0, "R8 full buffer no loss", loss_flag, 0);
      chk(drop_count === 0, "R8 full buffer no drops", drop_count, 0);
      for (int i = 0; i < 3; i++) step(1, 1, 0, 32'hC000 + i, 0, 1);
      idle(2, 0);
      @(negedge clk);
      chk(drop_count === 3, "R9 drop count", drop_count, 3);
      chk(loss_flag === 1, "R9 drop sets flag", loss_flag, 1);
      for (int i = 0; i < 6; i++) step(1, 1, 0, 32'hC100 + i, 0, 1);
      idle(2, 0);
      @(negedge clk);
      chk(drop_count === 7, "R9 saturation", drop_count, 7);
      @(posedge clk); #2 loss_clr = 1;
      @(posedge clk); #2 loss_clr = 0;
      @(negedge clk);
      chk(loss_flag === 0, "R11 clear", loss_flag, 0);
      idle(STALL + 50, 0);
      @(negedge clk);
      chk(loss_flag === 1, "R10 stall limit", loss_flag, 1);
      idle(30, 0);
      @(negedge clk);
      chk(loss_flag === 1, "R11 sticky", loss_flag, 1);
      drain(1);
      chk(expq.size() == 0, "R8 stored samples all sent", expq.size(), 0);
      chk(loss_flag === 1, "R11 sticky after drain", loss_flag, 1);
      @(posedge clk); #2 loss_clr = 1;
      @(posedge clk); #2 loss_clr = 0;
      @(negedge clk);
      chk(loss_flag === 0, "R11 clear after drain", loss_flag, 0);
      chk(drop_count === 7, "R9 count unaffected by clear", drop_count, 7);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule